// File: doc/BRIEF.md
# Color Standard Search Sequencer

This block decides which color standard the chroma decoder should try on the incoming video, one field at a time. It tracks the line standard (525 or 625 lines), walks a fixed rotating list of candidates that belong to that family, gives each candidate a fixed number of fields, and declares a lock once the decoder's per-field burst-match flag has been true for a programmable run of consecutive fields. While locked it reports the standard, a PAL identification bit, and turns on the luma notch filter with the matching carrier. A force input bypasses the search, and a mask removes candidates that are not expected.

All pins are plain level or strobe signals sampled on the rising clock edge. There is no data stream and therefore no valid/ready handshake and no back-pressure: `field_stb` is a one-cycle pulse per field and the block never stalls it. Outputs are registered state plus a small decode, so they change on the edge after the field strobe or the input change that causes them.

Standard codes: 0 none, 1 NTSC-M, 2 PAL-M, 3 PAL60, 4 NTSC 4.43, 5 PAL-B, 6 SECAM, 7 PAL-N.

Top module: `css_seq`

## Requirements
- R1: After reset `try_code` is 1, `locked` is 0, `det_code` is 0 and `notch_en` is 0.
- R2: With `lines625`=0 the candidates rotate 1,2,3,4,1...; with `lines625`=1 they rotate 5,6,7,5...; no other code is tried in auto mode.
- R3: Each candidate is tried for 30 field strobes when `fast_mode`=0 and 20 when `fast_mode`=1; on the last field of the window without a lock the next candidate is presented.
- R4: `cand_mask` bit i (bit 0 to bit 6) enables code i+1; a disabled candidate is skipped in the rotation, and a sole enabled candidate is retried indefinitely.
- R5: The block locks on the field where `burst_match` has been 1 for `lock_need` consecutive strobes within the current window; a 0 restarts the run; `lock_need`=0 acts as 1. A lock on the last field of a window takes priority over advancing.
- R6: While locked the candidate is held; lock is dropped after `lock_need` consecutive misses, after which the same candidate is retried with a fresh window.
- R7: A change of `lines625` drops any lock and presents the first enabled candidate of the new family on the next clock.
- R8: If no candidate of the active family is enabled, `try_code`, `det_code`, `locked`, `pal_id` and `notch_en` are all 0.
- R9: With `force_en`=1, `try_code` equals `force_code`, `locked` is 1 for a nonzero code, and the search is held at its first candidate until release.
- R10: `det_code` equals `try_code` while locked and 0 otherwise; `pal_id` is 1 only for a detected code 2, 3, 5 or 7.
- R11: `notch_en` is 1 only while locked with `luma_sep`=0; `notch_443` is then 1 for codes 3, 4, 5, 6 and 0 for codes 1, 2, 7 (3.58 MHz); both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_stb | input | 1 | One-cycle pulse per field |
| lines625 | input | 1 | Line standard: 1 = 625 lines, 0 = 525 lines |
| burst_match | input | 1 | Decoder confirms the current candidate on this field |
| force_en | input | 1 | Bypass search and use force_code |
| force_code | input | 3 | Standard code to force |
| cand_mask | input | 7 | Per-code enable for the search |
| fast_mode | input | 1 | 1 = short dwell window |
| luma_sep | input | 1 | Separate luma input; keeps the notch off |
| lock_need | input | RUN_W | Consecutive fields needed to lock or to lose lock |
| try_code | output | 3 | Candidate now being tried |
| locked | output | 1 | Standard confirmed |
| det_code | output | 3 | Detected standard, 0 when none |
| pal_id | output | 1 | Detected standard is a PAL variant |
| notch_en | output | 1 | Luma notch filter enable |
| notch_443 | output | 1 | Notch carrier: 1 = 4.43 MHz, 0 = 3.58 MHz |

## Verification
A corrupted dwell counter shows up as a candidate change on the wrong field, so sweeping every field of two full rotations in both speeds exposes it within one window of 20 or 30 fields. A wrong consecutive-run count shows as `locked` rising one field early or late against a lock time computed as candidate index times window plus run length. A stale candidate after a family change or mask change appears on `try_code` one clock after the input moves, and a bad attribute decode shows immediately on `pal_id` and `notch_443` for each forced code.

// File: rtl/css_pkg.sv
package css_pkg;
  localparam int NUM_STD = 7;
  localparam int FAM60_BASE = 1;
  localparam int FAM60_SIZE = 4;
  localparam int FAM50_BASE = 5;
  localparam int FAM50_SIZE = 3;
  localparam int MAX_FAM = 4;

  typedef logic [2:0] std_code_t;

  localparam std_code_t STD_NONE    = 3'd0;
  localparam std_code_t STD_NTSC_M  = 3'd1;
  localparam std_code_t STD_PAL_M   = 3'd2;
  localparam std_code_t STD_PAL60   = 3'd3;
  localparam std_code_t STD_NTSC443 = 3'd4;
  localparam std_code_t STD_PAL_B   = 3'd5;
  localparam std_code_t STD_SECAM   = 3'd6;
  localparam std_code_t STD_PAL_N   = 3'd7;
endpackage

// File: rtl/css_pick.sv
module css_pick
  import css_pkg::*;
(
  input  logic             fam625,
  input  logic [NUM_STD-1:0] mask,
  input  std_code_t        cur,
  output std_code_t        first,
  output std_code_t        next,
  output logic             any,
  output logic             cur_ok
);
  int base;
  int size;
  int cpos;

  always_comb begin
    base = fam625 ? FAM50_BASE : FAM60_BASE;
    size = fam625 ? FAM50_SIZE : FAM60_SIZE;
    first = STD_NONE;
    any = 1'b0;
    for (int k = 0; k < MAX_FAM; k++) begin
      if (k < size && !any && mask[base - 1 + k]) begin
        first = 3'(base + k);
        any = 1'b1;
      end
    end
    cpos = int'(cur) - base;
    cur_ok = (cpos >= 0) && (cpos < size) && (cur != STD_NONE) && mask[int'(cur) - 1];
    if (cpos < 0 || cpos >= size) cpos = size - 1;
    next = first;
    for (int off = MAX_FAM; off >= 1; off--) begin
      if (off <= size) begin
        if (mask[base - 1 + ((cpos + off) % size)]) next = 3'(base + ((cpos + off) % size));
      end
    end
  end
endmodule

// File: rtl/css_count.sv
module css_count #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (clr) q <= '0;
    else if (inc && q != {W{1'b1}}) q <= q + 1'b1;
  end
endmodule

// File: rtl/css_attr.sv
module css_attr
  import css_pkg::*;
(
  input  std_code_t code,
  output logic      is_pal,
  output logic      is_443
);
  always_comb begin
    is_pal = 1'b0;
    is_443 = 1'b0;
    unique case (code)
      STD_PAL_M:   is_pal = 1'b1;
      STD_PAL60:   begin is_pal = 1'b1; is_443 = 1'b1; end
      STD_NTSC443: is_443 = 1'b1;
      STD_PAL_B:   begin is_pal = 1'b1; is_443 = 1'b1; end
      STD_SECAM:   is_443 = 1'b1;
      STD_PAL_N:   is_pal = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/css_seq.sv
module css_seq
  import css_pkg::*;
#(
  parameter int DWELL_MED  = 30,
  parameter int DWELL_FAST = 20,
  parameter int RUN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic             lines625,
  input  logic             burst_match,
  input  logic             force_en,
  input  logic [2:0]       force_code,
  input  logic [6:0]       cand_mask,
  input  logic             fast_mode,
  input  logic             luma_sep,
  input  logic [RUN_W-1:0] lock_need,
  output logic [2:0]       try_code,
  output logic             locked,
  output logic [2:0]       det_code,
  output logic             pal_id,
  output logic             notch_en,
  output logic             notch_443
);
  localparam int DWELL_MAX = (DWELL_MED > DWELL_FAST) ? DWELL_MED : DWELL_FAST;
  localparam int DW_W = $clog2(DWELL_MAX + 1);

  std_code_t cand_q, cand_n;
  logic      lock_q, lock_n;
  logic      dw_clr, dw_inc, run_clr, run_inc;
  logic [DW_W-1:0]  dwell_q;
  logic [RUN_W-1:0] run_q;
  std_code_t first_c, next_c;
  logic      any_c, cur_ok;
  int        limit, need;
  logic      run_full, dwell_end;

  css_pick u_pick (
    .fam625 (lines625),
    .mask   (cand_mask),
    .cur    (cand_q),
    .first  (first_c),
    .next   (next_c),
    .any    (any_c),
    .cur_ok (cur_ok)
  );

  css_count #(.W(DW_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(dw_clr), .inc(dw_inc), .q(dwell_q)
  );

  css_count #(.W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc), .q(run_q)
  );

  always_comb begin
    limit = fast_mode ? DWELL_FAST : DWELL_MED;
    need = (lock_need == '0) ? 1 : int'(lock_need);
    run_full = (int'(run_q) + 1) >= need;
    dwell_end = (int'(dwell_q) + 1) >= limit;
    cand_n = cand_q;
    lock_n = lock_q;
    dw_clr = 1'b0;
    dw_inc = 1'b0;
    run_clr = 1'b0;
    run_inc = 1'b0;
    if (force_en || !cur_ok) begin
      cand_n = first_c;
      lock_n = 1'b0;
      dw_clr = 1'b1;
      run_clr = 1'b1;
    end else if (field_stb) begin
      if (!lock_q) begin
        if (burst_match && run_full) begin
          lock_n = 1'b1;
          run_clr = 1'b1;
          dw_clr = 1'b1;
        end else begin
          if (burst_match) run_inc = 1'b1;
          else run_clr = 1'b1;
          if (dwell_end) begin
            cand_n = next_c;
            dw_clr = 1'b1;
            run_clr = 1'b1;
          end else begin
            dw_inc = 1'b1;
          end
        end
      end else begin
        if (burst_match) run_clr = 1'b1;
        else if (run_full) begin
          lock_n = 1'b0;
          run_clr = 1'b1;
          dw_clr = 1'b1;
        end else run_inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= STD_NTSC_M;
      lock_q <= 1'b0;
    end else begin
      cand_q <= cand_n;
      lock_q <= lock_n;
    end
  end

  logic att_pal, att_443;

  always_comb begin
    try_code = force_en ? force_code : cand_q;
    locked = force_en ? (force_code != STD_NONE) : lock_q;
    det_code = locked ? try_code : STD_NONE;
  end

  css_attr u_attr (.code(det_code), .is_pal(att_pal), .is_443(att_443));

  assign pal_id = att_pal;
  assign notch_en = locked && !luma_sep && (det_code != STD_NONE);
  assign notch_443 = notch_en && att_443;
endmodule

// File: rtl/css_chk.sv
module css_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       field_stb,
  input logic       burst_match,
  input logic       force_en,
  input logic       lines625,
  input logic [6:0] cand_mask,
  input logic [2:0] try_code,
  input logic       locked,
  input logic [2:0] det_code,
  input logic       pal_id,
  input logic       notch_en
);
  logic fam_empty;
  assign fam_empty = lines625 ? (cand_mask[6:4] == 3'b000) : (cand_mask[3:0] == 4'b0000);

  assert_notch_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    notch_en |-> (locked && det_code != 3'd0));

  assert_det_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_code != 3'd0) |-> locked);

  assert_pal_det_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pal_id |-> (det_code != 3'd0));

  assert_lock_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && $past(!force_en) && $rose(locked)) |-> $past(field_stb && burst_match));

  assert_line_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && (lines625 != $past(lines625))) |=> (force_en || !locked));

  assert_empty_family_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && $past(!force_en) && $past(rst_n) && fam_empty && $stable(lines625) && $stable(cand_mask))
      |-> (try_code == 3'd0 && !locked));

  assert_step_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && $past(!force_en) && !$stable(try_code))
      |-> ($past(field_stb) || $past(cand_mask) != $past(cand_mask, 2)
           || $past(lines625) != $past(lines625, 2) || !$past(rst_n, 2) || $past(force_en, 2)));
endmodule

bind css_seq css_chk u_chk (
  .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .burst_match(burst_match),
  .force_en(force_en), .lines625(lines625), .cand_mask(cand_mask),
  .try_code(try_code), .locked(locked), .det_code(det_code),
  .pal_id(pal_id), .notch_en(notch_en)
);

// File: tb/sim_css_seq.sv
module sim_css_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_stb = 1'b0;
  logic lines625 = 1'b0;
  logic burst_match = 1'b0;
  logic force_en = 1'b0;
  logic [2:0] force_code = 3'd0;
  logic [6:0] cand_mask = 7'h7f;
  logic fast_mode = 1'b0;
  logic luma_sep = 1'b0;
  logic [3:0] lock_need = 4'd3;
  logic [2:0] try_code, det_code;
  logic locked, pal_id, notch_en, notch_443;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  css_seq u0 (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .lines625(lines625),
    .burst_match(burst_match), .force_en(force_en), .force_code(force_code),
    .cand_mask(cand_mask), .fast_mode(fast_mode), .luma_sep(luma_sep),
    .lock_need(lock_need), .try_code(try_code), .locked(locked),
    .det_code(det_code), .pal_id(pal_id), .notch_en(notch_en), .notch_443(notch_443)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    field_stb = 1'b0;
    burst_match = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic field(input bit bm);
    field_stb = 1'b1;
    burst_match = bm;
    @(negedge clk);
    field_stb = 1'b0;
    burst_match = 1'b0;
  endtask

  function automatic int exp_pal(input int c);
    return (c == 2 || c == 3 || c == 5 || c == 7) ? 1 : 0;
  endfunction

  function automatic int exp_443(input int c);
    return (c >= 3 && c <= 6) ? 1 : 0;
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lim, base, size, t, code;
    // R1 reset state
    do_reset();
    check("R1 try", try_code, 1);
    check("R1 locked", locked, 0);
    check("R1 det", det_code, 0);
    check("R1 notch", notch_en, 0);

    // R2/R3 dwell and rotation sweep, both families and speeds
    lock_need = 4'd15;
    for (int fam = 0; fam < 2; fam++) begin
      for (int sp = 0; sp < 2; sp++) begin
        lines625 = fam[0];
        fast_mode = sp[0];
        do_reset();
        lim = sp ? 20 : 30;
        base = fam ? 5 : 1;
        size = fam ? 3 : 4;
        check("R2 start", try_code, base);
        for (int j = 1; j <= 2 * size * lim; j++) begin
          field(1'b0);
          check("R3 dwell step", try_code, base + ((j / lim) % size));
        end
      end
    end

    // R5 lock time per target, R10/R11 status
    lock_need = 4'd3;
    for (int fam = 0; fam < 2; fam++) begin
      for (int sp = 0; sp < 2; sp++) begin
        base = fam ? 5 : 1;
        size = fam ? 3 : 4;
        lim = sp ? 20 : 30;
        for (int ti = 0; ti < size; ti++) begin
          lines625 = fam[0];
          fast_mode = sp[0];
          do_reset();
          code = base + ti;
          t = ti * lim + 3;
          for (int k = 0; k < t - 1; k++) field(try_code == code[2:0]);
          check("R5 not yet locked", locked, 0);
          field(try_code == code[2:0]);
          check("R5 locked", locked, 1);
          check("R10 det", det_code, code);
          check("R10 pal", pal_id, exp_pal(code));
          check("R11 notch en", notch_en, 1);
          check("R11 carrier", notch_443, exp_443(code));
        end
      end
    end

    // R5 broken run, R6 loss and fresh window
    lines625 = 1'b1;
    fast_mode = 1'b1;
    do_reset();
    field(1); field(1); field(0); field(1); field(1);
    check("R5 run restart", locked, 0);
    field(1);
    check("R5 lock after run", locked, 1);
    field(0); field(0);
    check("R6 two misses", locked, 1);
    field(1); field(0); field(0);
    check("R6 miss run restart", locked, 1);
    field(0);
    check("R6 lost", locked, 0);
    check("R6 same cand", try_code, 5);
    for (int k = 0; k < 19; k++) field(0);
    check("R6 fresh window", try_code, 5);
    field(0);
    check("R6 window end", try_code, 6);

    // R5 lock_need 0 acts as 1
    lines625 = 1'b0;
    lock_need = 4'd0;
    do_reset();
    field(1);
    check("R5 need zero", locked, 1);
    check("R11 ntsc carrier", notch_443, 0);
    luma_sep = 1'b1;
    #1;
    check("R11 luma sep", notch_en, 0);
    luma_sep = 1'b0;
    lock_need = 4'd3;

    // R7 line change
    lines625 = 1'b1;
    do_reset();
    field(1); field(1); field(1);
    check("R7 pre lock", locked, 1);
    lines625 = 1'b0;
    @(negedge clk);
    check("R7 unlock", locked, 0);
    check("R7 first cand", try_code, 1);
    cand_mask = 7'b1111100;
    lines625 = 1'b1;
    @(negedge clk);
    lines625 = 1'b0;
    @(negedge clk);
    check("R7 first enabled", try_code, 3);

    // R4 mask skip
    cand_mask = 7'b1111101;
    fast_mode = 1'b1;
    lines625 = 1'b0;
    do_reset();
    check("R4 start", try_code, 1);
    for (int k = 0; k < 20; k++) field(0);
    check("R4 skip", try_code, 3);
    for (int k = 0; k < 20; k++) field(0);
    check("R4 next", try_code, 4);
    for (int k = 0; k < 20; k++) field(0);
    check("R4 wrap", try_code, 1);
    cand_mask = 7'b0100000;
    lines625 = 1'b1;
    @(negedge clk);
    check("R4 sole", try_code, 6);
    for (int k = 0; k < 20; k++) field(0);
    check("R4 sole retry", try_code, 6);

    // R8 empty family
    cand_mask = 7'b0001111;
    @(negedge clk);
    for (int k = 0; k < 5; k++) field(1);
    check("R8 try", try_code, 0);
    check("R8 locked", locked, 0);
    check("R8 det", det_code, 0);
    check("R8 pal", pal_id, 0);
    check("R8 notch", notch_en, 0);
    cand_mask = 7'h7f;

    // R9 force
    lines625 = 1'b0;
    do_reset();
    for (int c = 0; c < 8; c++) begin
      force_en = 1'b1;
      force_code = c[2:0];
      @(negedge clk);
      check("R9 try", try_code, c);
      check("R9 locked", locked, c != 0 ? 1 : 0);
      check("R10 forced pal", pal_id, exp_pal(c));
      check("R11 forced carrier", notch_443, exp_443(c));
    end
    for (int k = 0; k < 4; k++) field(0);
    force_en = 1'b0;
    #1;
    check("R9 release", try_code, 1);
    check("R9 release lock", locked, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule